// File: doc/BRIEF.md
# Multi-Mode Position Counter

This block keeps a signed-direction position count for a motion axis. A decoder upstream of it turns the encoder's quadrature signals into one-cycle count strobes plus a direction bit. Each accepted strobe moves the counter one step up or down. Two mode bytes set how the count behaves:

- how it wraps or stops at its limits;
- how many bytes wide it is;
- what a marker (index) pulse does to it;
- which events may raise the interrupt.

A preset register serves three purposes: it is a load value, a range limit or modulus, and the operand of an equality comparator. A snapshot register freezes the live count so that software can read it while counting goes on.

Software talks to the block through a parallel command port. Each command is valid for one cycle and carries a 2-bit operation, a 3-bit register select and 32 bits of write data. A read returns its value on `rd_data_o` one cycle after the command, and the value holds until the next read. Events latch into a status byte. The active-low `flag_n_o` drops while any enabled event is latched.

Top module: `enc_pos_counter`

## Requirements

- R1: Reset (synchronous, active high) has the following effects:
  - Both mode bytes, the counter, the preset and the snapshot are cleared.
  - The power-loss bit (status bit 2) is set.
  - The direction bit is cleared.
  - `flag_n_o` is high.
- R2: An accepted step requires all of the following in the same cycle:
  - `step_i` is high;
  - `cnt_en_i` is high;
  - the software count-disable bit (mode1 bit 2) is 0.

  Otherwise the count holds. At most one step is taken per cycle, upward when `dir_up_i` is 1.
- R3: Count mode 00 (mode0 bits 1:0) is free-running:
  - An up step from the all-ones value of the active width gives 0 and raises carry.
  - A down step from 0 gives all-ones and raises borrow.
- R4: Count mode 01 is one-shot. It wraps like mode 00, but the step that raises carry or borrow halts counting. Counting resumes only after the counter is cleared or loaded, by command or by index action.
- R5: Count mode 10 is range-limited between 0 and the preset:
  - An up step at or above the preset is refused and raises carry.
  - A down step at 0 is refused and raises borrow.
  - Counting resumes as soon as a step goes the other way.
- R6: Count mode 11 is modulo preset+1:
  - An up step at the preset gives 0 and raises carry.
  - A down step at 0 gives the preset and raises borrow.
- R7: The width code in mode1 bits 1:0 selects 4, 3, 2 or 1 bytes for codes 00, 01, 10 and 11. The counter, the preset and the snapshot are used and read back masked to that width.
- R8: A compare event is raised when an accepted step leaves the counter equal to the masked preset.
- R9: When `index_i` is high, mode0 bits 3:2 select its action:
  - 00: no action;
  - 01: copy the preset into the counter;
  - 10: clear the counter;
  - 11: copy the counter into the snapshot.
- R10: The snapshot takes the masked counter value in any of these cases:
  - on a falling edge of `snap_n_i`;
  - on a load-snapshot command;
  - on a read-counter command;
  - on the index snapshot action.
- R11: The status byte is laid out from bit 7 down as follows:
  - bit 7: carry;
  - bit 6: borrow;
  - bit 5: compare;
  - bit 4: index;
  - bit 3: live count-enable (`cnt_en_i` and not software disable);
  - bit 2: power-loss;
  - bit 1: direction of the last accepted step;
  - bit 0: reads 0.

  Bits 7..4 latch only when the matching mode1 bit 7..4 is set, and stay set until a clear-status command. Clear-status clears bits 7..4 and bit 2, and wins over events in the same cycle.
- R12: `flag_n_o` is low exactly when a status bit among 7..4 is set together with its mode1 enable bit.
- R13: Commands decode as follows:
  - Operations: 00 clear, 01 read, 10 write, 11 load.
  - Selects: 1 mode0, 2 mode1, 3 preset, 4 counter, 5 snapshot, 6 status.
  - Clear acts on mode0, mode1, counter and status.
  - Read returns mode0, mode1, counter, snapshot or status; any other select returns 0.
  - Write sets mode0, mode1 (low byte) or the preset.
  - Load copies the preset into the counter (select 4) or the counter into the snapshot (select 5).
  - A counter clear or load by command or by index overrides a step in the same cycle, and the step is dropped.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Hardware count enable |
| step_i | input | 1 | One-cycle count strobe |
| dir_up_i | input | 1 | Step direction, 1 = up |
| index_i | input | 1 | Marker event strobe |
| snap_n_i | input | 1 | Snapshot request, acts on falling edge |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command operation |
| cmd_sel_i | input | 3 | Register select |
| cmd_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read result, valid the cycle after a read |
| flag_n_o | output | 1 | Active-low interrupt flag |

## Verification

The hardest state to reach is a one-shot halt. Proving that the halt releases only on a counter clear or load needs three things: a preset loaded just below the wrap point of a narrow width, steps that continue past the halt, and then a release. The bench reaches it with the 1-byte width, a preset loaded into the counter, and directed steps across the all-ones boundary, followed by further refused steps. Command-versus-step collisions are also hard to reach, because they need a step strobe and a counter command in the same cycle. The bench forces them directly and also sprinkles them through random runs in which the modes and the width change every fifty cycles.

// File: rtl/epc_pkg.sv
package epc_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 4;
    localparam int CNT_W     = BYTE_W * NUM_BYTES;
    localparam int EV_N      = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        OP_CLR = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_LD  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        SEL_NONE_LO = 3'd0,
        SEL_MODE0   = 3'd1,
        SEL_MODE1   = 3'd2,
        SEL_PRESET  = 3'd3,
        SEL_COUNT   = 3'd4,
        SEL_SNAP    = 3'd5,
        SEL_STATUS  = 3'd6,
        SEL_NONE_HI = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        CM_FREE    = 2'b00,
        CM_ONESHOT = 2'b01,
        CM_RANGE   = 2'b10,
        CM_MODULO  = 2'b11
    } cmode_e;

    typedef enum logic [1:0] {
        IX_NONE  = 2'b00,
        IX_LOAD  = 2'b01,
        IX_CLEAR = 2'b10,
        IX_SNAP  = 2'b11
    } ixact_e;

    typedef struct packed {
        logic carry;
        logic borrow;
        logic match;
    } step_ev_t;

    typedef struct packed {
        logic clr_m0;
        logic clr_m1;
        logic clr_cnt;
        logic clr_stat;
        logic wr_m0;
        logic wr_m1;
        logic wr_pre;
        logic ld_cnt;
        logic ld_snap;
        logic rd_en;
    } cmd_t;

    // Ones over the active bytes; code 0 selects all bytes, each step drops one.
    function automatic cnt_t width_mask(input logic [1:0] code);
        cnt_t m;
        m = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (b < NUM_BYTES - int'(code)) m[b*BYTE_W +: BYTE_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/epc_cmd_decode.sv
module epc_cmd_decode
    import epc_pkg::*;
(
    input  logic       valid_i,
    input  op_e        op_i,
    input  sel_e       sel_i,
    output cmd_t       cmd_o
);

    always_comb begin
        cmd_o = '0;
        if (valid_i) begin
            unique case (op_i)
                OP_CLR: begin
                    cmd_o.clr_m0   = (sel_i == SEL_MODE0);
                    cmd_o.clr_m1   = (sel_i == SEL_MODE1);
                    cmd_o.clr_cnt  = (sel_i == SEL_COUNT);
                    cmd_o.clr_stat = (sel_i == SEL_STATUS);
                end
                OP_RD: begin
                    cmd_o.rd_en   = 1'b1;
                    cmd_o.ld_snap = (sel_i == SEL_COUNT);
                end
                OP_WR: begin
                    cmd_o.wr_m0  = (sel_i == SEL_MODE0);
                    cmd_o.wr_m1  = (sel_i == SEL_MODE1);
                    cmd_o.wr_pre = (sel_i == SEL_PRESET);
                end
                OP_LD: begin
                    cmd_o.ld_cnt  = (sel_i == SEL_COUNT);
                    cmd_o.ld_snap = (sel_i == SEL_SNAP);
                end
                default: cmd_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/epc_step_unit.sv
module epc_step_unit
    import epc_pkg::*;
(
    input  cmode_e   mode_i,
    input  logic     up_i,
    input  cnt_t     cur_i,
    input  cnt_t     preset_i,
    input  cnt_t     mask_i,
    output cnt_t     nxt_o,
    output step_ev_t ev_o,
    output logic     halt_req_o
);

    localparam cnt_t ONE = cnt_t'(1);

    always_comb begin
        nxt_o = cur_i;
        ev_o  = '0;
        if (up_i) begin
            unique case (mode_i)
                CM_RANGE: begin
                    if (cur_i >= preset_i) ev_o.carry = 1'b1;
                    else                   nxt_o = cur_i + ONE;
                end
                CM_MODULO: begin
                    if (cur_i == preset_i) begin
                        nxt_o = '0;
                        ev_o.carry = 1'b1;
                    end else begin
                        nxt_o = (cur_i + ONE) & mask_i;
                    end
                end
                default: begin
                    if (cur_i == mask_i) begin
                        nxt_o = '0;
                        ev_o.carry = 1'b1;
                    end else begin
                        nxt_o = cur_i + ONE;
                    end
                end
            endcase
        end else begin
            unique case (mode_i)
                CM_RANGE: begin
                    if (cur_i == '0) ev_o.borrow = 1'b1;
                    else             nxt_o = cur_i - ONE;
                end
                CM_MODULO: begin
                    if (cur_i == '0) begin
                        nxt_o = preset_i;
                        ev_o.borrow = 1'b1;
                    end else begin
                        nxt_o = cur_i - ONE;
                    end
                end
                default: begin
                    if (cur_i == '0) begin
                        nxt_o = mask_i;
                        ev_o.borrow = 1'b1;
                    end else begin
                        nxt_o = cur_i - ONE;
                    end
                end
            endcase
        end
        ev_o.match = (nxt_o == preset_i);
        halt_req_o = (mode_i == CM_ONESHOT) && (ev_o.carry || ev_o.borrow);
    end

endmodule

// File: rtl/epc_status.sv
module epc_status
    import epc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic [EV_N-1:0] ev_i,
    input  logic [EV_N-1:0] ev_en_i,
    input  logic            dir_we_i,
    input  logic            dir_i,
    output logic [EV_N-1:0] lat_o,
    output logic            pwr_o,
    output logic            dir_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_o <= '0;
            pwr_o <= 1'b1;
            dir_o <= 1'b0;
        end else begin
            if (dir_we_i) dir_o <= dir_i;
            if (clr_i) begin
                lat_o <= '0;
                pwr_o <= 1'b0;
            end else begin
                lat_o <= lat_o | (ev_i & ev_en_i);
            end
        end
    end

endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
    import epc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en_i,
    input  logic             step_i,
    input  logic             dir_up_i,
    input  logic             index_i,
    input  logic             snap_n_i,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_op_i,
    input  logic [2:0]       cmd_sel_i,
    input  logic [CNT_W-1:0] cmd_wdata_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             flag_n_o
);

    localparam int PAD_W = CNT_W - BYTE_W;

    logic [BYTE_W-1:0] mode0_q, mode1_q;
    cnt_t              preset_q, cnt_q, snap_q, rd_q;
    logic              halt_q, snap_n_q;

    cmd_t              cmd_s;
    cnt_t              mask, cur, pre, nxt;
    step_ev_t          sev;
    logic              halt_req;
    cmode_e            cmode;
    ixact_e            ixact;
    logic              live_en, ix_load, ix_clear, ix_snap;
    logic              cnt_override, step_go, snap_take;
    logic [EV_N-1:0]   stat_lat;
    logic              stat_pwr, stat_dir;
    logic [BYTE_W-1:0] status_byte;

    epc_cmd_decode u_dec (
        .valid_i (cmd_valid_i),
        .op_i    (op_e'(cmd_op_i)),
        .sel_i   (sel_e'(cmd_sel_i)),
        .cmd_o   (cmd_s)
    );

    assign mask    = width_mask(mode1_q[1:0]);
    assign cur     = cnt_q & mask;
    assign pre     = preset_q & mask;
    assign cmode   = cmode_e'(mode0_q[1:0]);
    assign ixact   = ixact_e'(mode0_q[3:2]);
    assign live_en = cnt_en_i & ~mode1_q[2];

    assign ix_load  = index_i && (ixact == IX_LOAD);
    assign ix_clear = index_i && (ixact == IX_CLEAR);
    assign ix_snap  = index_i && (ixact == IX_SNAP);

    assign cnt_override = cmd_s.clr_cnt | cmd_s.ld_cnt | ix_load | ix_clear;
    assign step_go      = step_i & live_en & ~halt_q & ~cnt_override;
    assign snap_take    = cmd_s.ld_snap | ix_snap | (snap_n_q & ~snap_n_i);

    epc_step_unit u_step (
        .mode_i     (cmode),
        .up_i       (dir_up_i),
        .cur_i      (cur),
        .preset_i   (pre),
        .mask_i     (mask),
        .nxt_o      (nxt),
        .ev_o       (sev),
        .halt_req_o (halt_req)
    );

    epc_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (cmd_s.clr_stat),
        .ev_i     ({step_go & sev.carry, step_go & sev.borrow,
                    step_go & sev.match, index_i}),
        .ev_en_i  (mode1_q[7:4]),
        .dir_we_i (step_go),
        .dir_i    (dir_up_i),
        .lat_o    (stat_lat),
        .pwr_o    (stat_pwr),
        .dir_o    (stat_dir)
    );

    assign status_byte = {stat_lat, live_en, stat_pwr, stat_dir, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode0_q  <= '0;
            mode1_q  <= '0;
            preset_q <= '0;
            cnt_q    <= '0;
            snap_q   <= '0;
            rd_q     <= '0;
            halt_q   <= 1'b0;
            snap_n_q <= 1'b1;
        end else begin
            snap_n_q <= snap_n_i;

            if (cmd_s.clr_m0)     mode0_q <= '0;
            else if (cmd_s.wr_m0) mode0_q <= cmd_wdata_i[BYTE_W-1:0];
            if (cmd_s.clr_m1)     mode1_q <= '0;
            else if (cmd_s.wr_m1) mode1_q <= cmd_wdata_i[BYTE_W-1:0];
            if (cmd_s.wr_pre)     preset_q <= cmd_wdata_i;

            if (cmd_s.clr_cnt)     cnt_q <= '0;
            else if (cmd_s.ld_cnt) cnt_q <= pre;
            else if (ix_load)      cnt_q <= pre;
            else if (ix_clear)     cnt_q <= '0;
            else if (step_go)      cnt_q <= nxt;

            if (cnt_override)             halt_q <= 1'b0;
            else if (step_go && halt_req) halt_q <= 1'b1;

            if (snap_take) snap_q <= cur;

            if (cmd_s.rd_en) begin
                unique case (sel_e'(cmd_sel_i))
                    SEL_MODE0:  rd_q <= {{PAD_W{1'b0}}, mode0_q};
                    SEL_MODE1:  rd_q <= {{PAD_W{1'b0}}, mode1_q};
                    SEL_COUNT:  rd_q <= cur;
                    SEL_SNAP:   rd_q <= snap_q & mask;
                    SEL_STATUS: rd_q <= {{PAD_W{1'b0}}, status_byte};
                    default:    rd_q <= '0;
                endcase
            end
        end
    end

    assign rd_data_o = rd_q;
    assign flag_n_o  = ~|(stat_lat & mode1_q[7:4]);

endmodule

// File: rtl/epc_checker.sv
module epc_checker
    import epc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            snap_n_i,
    input logic            cmd_valid_i,
    input logic [1:0]      cmd_op_i,
    input logic [7:0]      mode0_q,
    input logic [7:0]      mode1_q,
    input cnt_t            cnt_q,
    input cnt_t            snap_q,
    input cnt_t            mask,
    input cnt_t            rd_data_o,
    input logic            halt_q,
    input logic            cnt_override,
    input logic [EV_N-1:0] stat_lat,
    input logic            stat_pwr,
    input logic            clr_stat
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mode0_q == '0 && mode1_q == '0 && cnt_q == '0 && stat_pwr));

    // R2
    sw_disable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode1_q[2] && !cnt_override) |=> cnt_q == $past(cnt_q));

    // R4
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_q && !cnt_override) |=> cnt_q == $past(cnt_q));

    // R11
    sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_lat != '0 && !clr_stat) |=> (($past(stat_lat) & ~stat_lat) == '0));

    // R10
    snap_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(snap_n_i) |=> snap_q == $past(cnt_q & mask));

    // R7
    read_width_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_op_i == 2'b01) |=> ((rd_data_o & ~$past(mask)) == '0));

endmodule

bind enc_pos_counter epc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .snap_n_i     (snap_n_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .mode0_q      (mode0_q),
    .mode1_q      (mode1_q),
    .cnt_q        (cnt_q),
    .snap_q       (snap_q),
    .mask         (mask),
    .rd_data_o    (rd_data_o),
    .halt_q       (halt_q),
    .cnt_override (cnt_override),
    .stat_lat     (stat_lat),
    .stat_pwr     (stat_pwr),
    .clr_stat     (cmd_s.clr_stat)
);

// File: tb/enc_pos_counter_tb.sv
module enc_pos_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] CLR = 2'b00, RD = 2'b01, WR = 2'b10, LD = 2'b11;
    localparam logic [2:0] S_M0 = 3'd1, S_M1 = 3'd2, S_PRE = 3'd3,
                           S_CNT = 3'd4, S_SNAP = 3'd5, S_STAT = 3'd6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en_i = 1'b1;
    logic        step_i = 1'b0, dir_up_i = 1'b1, index_i = 1'b0, snap_n_i = 1'b1;
    logic        cmd_valid_i = 1'b0;
    logic [1:0]  cmd_op_i = 2'b00;
    logic [2:0]  cmd_sel_i = 3'd0;
    logic [31:0] cmd_wdata_i = '0;
    logic [31:0] rd_data_o;
    logic        flag_n_o;

    int checks = 0;
    int errors = 0;
    logic snap_lvl = 1'b1;

    // bench model state
    logic [7:0]  m_m0, m_m1;
    logic [31:0] m_pre, m_cnt, m_snap, m_rd;
    logic [3:0]  m_lat;
    logic        m_pwr, m_dir, m_halt, m_snprev;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_pos_counter u_dut (
        .clk(clk), .rst(rst), .cnt_en_i(cnt_en_i), .step_i(step_i),
        .dir_up_i(dir_up_i), .index_i(index_i), .snap_n_i(snap_n_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_sel_i(cmd_sel_i),
        .cmd_wdata_i(cmd_wdata_i), .rd_data_o(rd_data_o), .flag_n_o(flag_n_o)
    );

    function automatic logic [31:0] exp_mask(input logic [1:0] code);
        int nb;
        nb = 4 - int'(code);
        if (nb == 4) return 32'hFFFF_FFFF;
        return (32'd1 << (8*nb)) - 32'd1;
    endfunction

    function automatic logic exp_flag();
        return !(|(m_lat & m_m1[7:4]));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_m0 = '0; m_m1 = '0; m_pre = '0; m_cnt = '0; m_snap = '0; m_rd = '0;
        m_lat = '0; m_pwr = 1'b1; m_dir = 1'b0; m_halt = 1'b0; m_snprev = 1'b1;
    endtask

    task automatic model_cycle(input logic st, input logic up, input logic ix,
                               input logic sn, input logic cv, input logic [1:0] op,
                               input logic [2:0] sel, input logic [31:0] wd);
        logic [31:0] mk, c, p, n;
        logic cy, bw, mt, go, ovr, ixl, ixc, ixs, cclr, cld;
        mk = exp_mask(m_m1[1:0]);
        c  = m_cnt & mk;
        p  = m_pre & mk;
        ixl = ix && m_m0[3:2] == 2'b01;
        ixc = ix && m_m0[3:2] == 2'b10;
        ixs = ix && m_m0[3:2] == 2'b11;
        cclr = cv && op == CLR && sel == S_CNT;
        cld  = cv && op == LD && sel == S_CNT;
        ovr = ixl || ixc || cclr || cld;
        go  = st && cnt_en_i && !m_m1[2] && !m_halt && !ovr;
        cy = 1'b0; bw = 1'b0; n = c;
        if (up) begin
            case (m_m0[1:0])
                2'b10: if (c >= p) cy = 1'b1; else n = c + 1;
                2'b11: if (c == p) begin n = 0; cy = 1'b1; end else n = (c + 1) & mk;
                default: if (c == mk) begin n = 0; cy = 1'b1; end else n = c + 1;
            endcase
        end else begin
            case (m_m0[1:0])
                2'b10: if (c == 0) bw = 1'b1; else n = c - 1;
                2'b11: if (c == 0) begin n = p; bw = 1'b1; end else n = c - 1;
                default: if (c == 0) begin n = mk; bw = 1'b1; end else n = c - 1;
            endcase
        end
        mt = (n == p);
        if (cv && op == RD) begin
            case (sel)
                S_M0:   m_rd = {24'd0, m_m0};
                S_M1:   m_rd = {24'd0, m_m1};
                S_CNT:  m_rd = c;
                S_SNAP: m_rd = m_snap & mk;
                S_STAT: m_rd = {24'd0, m_lat, cnt_en_i & ~m_m1[2], m_pwr, m_dir, 1'b0};
                default: m_rd = '0;
            endcase
        end
        if (ixs || (cv && op == LD && sel == S_SNAP) || (cv && op == RD && sel == S_CNT)
            || (m_snprev && !sn)) m_snap = c;
        m_snprev = sn;
        if (cv && op == CLR && sel == S_STAT) begin
            m_lat = '0; m_pwr = 1'b0;
        end else begin
            m_lat = m_lat | ({go & cy, go & bw, go & mt, ix} & m_m1[7:4]);
        end
        if (go) m_dir = up;
        if (ovr) m_halt = 1'b0;
        else if (go && m_m0[1:0] == 2'b01 && (cy || bw)) m_halt = 1'b1;
        if (cclr) m_cnt = 0;
        else if (cld || ixl) m_cnt = p;
        else if (ixc) m_cnt = 0;
        else if (go) m_cnt = n;
        if (cv && op == CLR && sel == S_M0) m_m0 = '0;
        else if (cv && op == WR && sel == S_M0) m_m0 = wd[7:0];
        if (cv && op == CLR && sel == S_M1) m_m1 = '0;
        else if (cv && op == WR && sel == S_M1) m_m1 = wd[7:0];
        if (cv && op == WR && sel == S_PRE) m_pre = wd;
    endtask

    task automatic tick(input logic st, input logic up, input logic ix, input logic sn,
                        input logic cv, input logic [1:0] op, input logic [2:0] sel,
                        input logic [31:0] wd);
        @(negedge clk);
        step_i = st; dir_up_i = up; index_i = ix; snap_n_i = sn;
        cmd_valid_i = cv; cmd_op_i = op; cmd_sel_i = sel; cmd_wdata_i = wd;
        model_cycle(st, up, ix, sn, cv, op, sel, wd);
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        tick(1'b0, 1'b1, 1'b0, snap_lvl, 1'b0, CLR, 3'd0, '0);
    endtask

    task automatic steps(input logic up, input int n);
        for (int i = 0; i < n; i++) tick(1'b1, up, 1'b0, snap_lvl, 1'b0, CLR, 3'd0, '0);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [2:0] sel, input logic [31:0] wd);
        tick(1'b0, 1'b1, 1'b0, snap_lvl, 1'b1, op, sel, wd);
    endtask

    task automatic index_pulse();
        tick(1'b0, 1'b1, 1'b1, snap_lvl, 1'b0, CLR, 3'd0, '0);
    endtask

    // read, compare with a fixed expectation and with the model, and check the flag
    task automatic read_exp(input logic [2:0] sel, input logic [31:0] exp, input string req);
        cmd(RD, sel, '0);
        check(req, rd_data_o, exp);
        check(req, rd_data_o, m_rd);
        check("R12 flag", {31'd0, flag_n_o}, {31'd0, exp_flag()});
    endtask

    task automatic read_mdl(input logic [2:0] sel, input string req);
        cmd(RD, sel, '0);
        check(req, rd_data_o, m_rd);
        check("R12 flag", {31'd0, flag_n_o}, {31'd0, exp_flag()});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;

        // R1 reset state
        check("R1 flag idle", {31'd0, flag_n_o}, 32'd1);
        read_exp(S_STAT, 32'h0C, "R1 status after reset");
        read_exp(S_CNT, 32'h0, "R1 counter after reset");
        read_exp(S_M0, 32'h0, "R1 mode0 after reset");

        // R3 / R8 / R11 / R12: one byte, all events enabled
        cmd(WR, S_M1, 32'hF3);
        cmd(CLR, S_CNT, '0);
        steps(1'b0, 1);
        read_exp(S_CNT, 32'hFF, "R3 borrow wrap");
        read_exp(S_STAT, 32'h4C, "R11 borrow latched");
        check("R12 flag low", {31'd0, flag_n_o}, 32'd0);
        steps(1'b1, 1);
        read_exp(S_CNT, 32'h00, "R3 carry wrap");
        read_exp(S_STAT, 32'hEE, "R8 compare and carry latched");
        cmd(CLR, S_STAT, '0);
        read_exp(S_STAT, 32'h0A, "R11 clear status");
        check("R12 flag released", {31'd0, flag_n_o}, 32'd1);

        // R7 width, R13 priority
        cmd(WR, S_M1, 32'h02);
        cmd(WR, S_PRE, 32'h0001_2345);
        cmd(LD, S_CNT, '0);
        read_exp(S_CNT, 32'h2345, "R7 two-byte load");
        tick(1'b1, 1'b1, 1'b0, snap_lvl, 1'b1, LD, S_CNT, '0);
        read_exp(S_CNT, 32'h2345, "R13 load beats step");
        tick(1'b1, 1'b1, 1'b0, snap_lvl, 1'b1, CLR, S_CNT, '0);
        read_exp(S_CNT, 32'h0, "R13 clear beats step");
        read_exp(S_PRE, 32'h0, "R13 preset not readable");

        // R6 modulo
        cmd(WR, S_M0, 32'h03);
        cmd(WR, S_M1, 32'h80);
        cmd(WR, S_PRE, 32'd4);
        cmd(CLR, S_CNT, '0);
        steps(1'b1, 4);
        read_exp(S_CNT, 32'd4, "R6 reach modulus");
        steps(1'b1, 1);
        read_exp(S_CNT, 32'd0, "R6 up wrap");
        check("R12 carry flag", {31'd0, flag_n_o}, 32'd0);
        steps(1'b0, 1);
        read_exp(S_CNT, 32'd4, "R6 down wrap");
        cmd(CLR, S_STAT, '0);

        // R5 range
        cmd(WR, S_M0, 32'h02);
        cmd(WR, S_PRE, 32'd3);
        cmd(CLR, S_CNT, '0);
        steps(1'b1, 6);
        read_exp(S_CNT, 32'd3, "R5 upper clamp");
        steps(1'b0, 5);
        read_exp(S_CNT, 32'd0, "R5 lower clamp");
        steps(1'b1, 1);
        read_exp(S_CNT, 32'd1, "R5 resume on reversal");

        // R4 one-shot
        cmd(WR, S_M0, 32'h01);
        cmd(WR, S_M1, 32'h03);
        cmd(WR, S_PRE, 32'hFE);
        cmd(LD, S_CNT, '0);
        steps(1'b1, 3);
        read_exp(S_CNT, 32'd0, "R4 halted after carry");
        steps(1'b0, 2);
        read_exp(S_CNT, 32'd0, "R4 still halted");
        cmd(CLR, S_CNT, '0);
        steps(1'b1, 1);
        read_exp(S_CNT, 32'd1, "R4 resumed after clear");

        // R2 gating
        cmd(WR, S_M0, 32'h00);
        cmd(WR, S_M1, 32'h00);
        cmd(CLR, S_CNT, '0);
        cnt_en_i = 1'b0;
        steps(1'b1, 3);
        read_exp(S_CNT, 32'd0, "R2 hardware enable low");
        cnt_en_i = 1'b1;
        cmd(WR, S_M1, 32'h04);
        steps(1'b1, 2);
        read_exp(S_CNT, 32'd0, "R2 software disable");
        read_mdl(S_STAT, "R11 live enable bit");
        cmd(WR, S_M1, 32'h00);
        steps(1'b1, 1);
        read_exp(S_CNT, 32'd1, "R2 enabled again");

        // R9 index actions
        cmd(WR, S_M0, 32'h04);
        cmd(WR, S_PRE, 32'd7);
        index_pulse();
        read_exp(S_CNT, 32'd7, "R9 index load");
        cmd(WR, S_M0, 32'h08);
        index_pulse();
        read_exp(S_CNT, 32'd0, "R9 index clear");
        steps(1'b1, 2);
        cmd(WR, S_M0, 32'h0C);
        index_pulse();
        steps(1'b1, 1);
        read_exp(S_SNAP, 32'd2, "R9 index snapshot");
        read_exp(S_CNT, 32'd3, "R9 counter unaffected");

        // R10 snapshot strobe
        cmd(WR, S_M0, 32'h00);
        snap_lvl = 1'b0;
        idle();
        steps(1'b1, 2);
        snap_lvl = 1'b1;
        idle();
        read_exp(S_SNAP, 32'd3, "R10 falling edge capture");
        cmd(LD, S_SNAP, '0);
        read_exp(S_SNAP, 32'd5, "R10 load snapshot command");

        // random phase
        for (int i = 0; i < 1200; i++) begin
            if (i % 50 == 0) begin
                cmd(WR, S_M0, $urandom & 32'h0F);
                cmd(WR, S_M1, $urandom & 32'hF3);
                cmd(WR, S_PRE, ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h1F));
            end
            if (i % 7 == 0) begin
                read_mdl(S_CNT, "R3 R5 R6 random count");
            end else if (i % 23 == 0) begin
                read_mdl(S_STAT, "R11 random status");
            end else if (i % 31 == 0) begin
                tick($urandom % 2 == 0, $urandom % 2 == 0, 1'b0, snap_lvl, 1'b1,
                     ($urandom % 2 == 0) ? CLR : LD, S_CNT, '0);
            end else begin
                if ($urandom % 10 == 0) snap_lvl = ~snap_lvl;
                tick($urandom % 10 < 7, $urandom % 3 != 0, $urandom % 20 == 0, snap_lvl,
                     1'b0, CLR, 3'd0, '0);
            end
        end
        read_mdl(S_SNAP, "R10 random snapshot");
        read_mdl(S_STAT, "R11 final status");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule